// File: doc/BRIEF.md
# Two-rail serial avionics word transmitter with eight-word queue

This block takes words from a host 16 bits at a time, queues up to eight complete 32-bit words, and sends them one after another on a pair of digital rail outputs. It uses the bipolar return-to-zero code of the ARINC 429 bus. In each bit period one rail pulses high for the first half, then both rails rest low for the second half. The host first writes the low half into a staging register. The word is committed to the queue only when the high half is written. A control input picks a 32-bit or 25-bit word length, and a second control input picks odd or even parity. The top bit of each sent word is always the parity bit that the block computes, whatever the host wrote in that position.

Words sent one after another form a transmit set. Each word is followed by a fixed number of null bit periods. The ready output is low while any word is queued or being sent, and it returns high once the set has finished and the queue is empty. Inverting ready and feeding it to the transmit enable starts sending as soon as the first word is committed. The host may append words while the first word of a set is still on the line. Once a later word of the set has started, the queue is closed to writes until the set ends. Any write attempted in that window, or a commit into a full queue, is dropped and raises a sticky error output.

Top module: `a429_tx_fifo`

## Requirements
- R1: After reset both rails are low, the ready output is high and the error output is low.
- R2: A low-half strobe only stages 16 bits and never starts a transmission. A high-half strobe commits the word {high half in bits 31:16, staged low half in bits 15:0} to the queue.
- R3: Bits are sent LSB first. A 1 drives line_a and a 0 drives line_b, each high for exactly HALF_BIT_CYC clock cycles, followed by HALF_BIT_CYC cycles with both rails low. Consecutive bits of a word begin 2*HALF_BIT_CYC cycles apart.
- R4: With cfg_len25 low, 32 bits are sent: bits 0 to 30 of the stored word, then a parity bit in position 31.
- R5: With cfg_len25 high, 25 bits are sent: bits 0 to 23 of the stored word, then a parity bit in position 24.
- R6: The parity bit makes the count of ones in the sent word odd when cfg_even is low and even when cfg_even is high. The host's own value in that position has no effect.
- R7: The queue holds eight words and sends them in the order they were written. A commit into a full queue is dropped and sets the error output.
- R8: The first bit of a word begins at least (1+GAP_BITS) bit periods after the last bit of the previous word began.
- R9: A word starts only while tx_en is high. Ready is low whenever a word is queued or on the line, including its gap. Ready is high again only when the set is complete, and both rails are low whenever ready is high.
- R10: Writes are accepted while the first word of a set is being sent. Once a later word of the set has started, both strobes are ignored and the error output is set. Writes are accepted again after ready returns high.
- R11: The error output stays high until reset, and the two rails are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len25 | input | 1 | 1 selects 25-bit words, 0 selects 32-bit words |
| cfg_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| tx_en | input | 1 | Allows a queued word to start |
| wr_lo | input | 1 | Single-cycle strobe that stages the low half |
| wr_hi | input | 1 | Single-cycle strobe that commits the high half and the whole word |
| wr_data | input | 16 | Half-word from the host |
| line_a | output | 1 | Rail that pulses for a 1 bit |
| line_b | output | 1 | Rail that pulses for a 0 bit |
| tx_ready | output | 1 | High when no word is queued or being sent |
| wr_err | output | 1 | Sticky flag for a dropped write |

## Verification
The bench builds the block with an eight-word queue, two clock cycles per half bit and four gap bits. A 32-bit word then takes about 150 cycles including its gap, so a full queue drains in a short run. The short bit period lets the bench watch every rail pulse and measure its width, the bit spacing and the gap between words against the rule for each. An eight-deep queue makes both the full-queue drop and the locked window after the second word easy to reach from directed write sequences.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_BITS,
        SER_GAP
    } ser_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tx_word_t;

    // Builds the word as it goes on the line: parity replaces the top bit
    // of the selected length, and bits above a short word are cleared.
    function automatic logic [WORD_W-1:0] frame_word(tx_word_t w, logic len25, logic even);
        logic [WORD_W-1:0] d;
        logic              p;
        d = {w.hi, w.lo};
        if (len25) begin
            p       = ^d[23:0];
            d[31:24] = '0;
            d[24]   = even ? p : ~p;
        end else begin
            p     = ^d[30:0];
            d[31] = even ? p : ~p;
        end
        return d;
    endfunction

endpackage

// File: rtl/a429_tx_store.sv
module a429_tx_store
    import a429_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              pop,
    input  logic              set_done,
    output tx_word_t          head,
    output logic              empty,
    output logic [CW-1:0]     fill,
    output logic              err
);

    tx_word_t          mem [DEPTH];
    logic [HALF_W-1:0] stage_lo;
    logic [AW-1:0]     rd_ptr, wr_ptr;
    logic              in_set, locked;
    logic              full, lo_ok, push, bad_wr;

    assign full   = (fill == CW'(DEPTH));
    assign empty  = (fill == '0);
    assign lo_ok  = wr_lo & ~locked;
    assign push   = wr_hi & ~locked & ~full;
    assign bad_wr = ((wr_lo | wr_hi) & locked) | (wr_hi & ~locked & full);
    assign head   = mem[rd_ptr];

    function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= '{hi: wr_data, lo: stage_lo};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            fill     <= '0;
            in_set   <= 1'b0;
            locked   <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (lo_ok) stage_lo <= wr_data;
            if (push)  wr_ptr   <= ptr_next(wr_ptr);
            if (pop)   rd_ptr   <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
            if (bad_wr) err <= 1'b1;
            // The first pop opens a set; any later pop in it closes the queue.
            if (set_done) begin
                in_set <= 1'b0;
                locked <= 1'b0;
            end else if (pop) begin
                in_set <= 1'b1;
                if (in_set) locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/a429_tx_serial.sv
module a429_tx_serial
    import a429_tx_pkg::*;
#(
    parameter int HALF_BIT_CYC = 2,
    parameter int GAP_BITS     = 4,
    localparam int BIT_CYC = 2 * HALF_BIT_CYC,
    localparam int GAP_CYC = GAP_BITS * BIT_CYC,
    localparam int PH_W    = $clog2(BIT_CYC),
    localparam int GC_W    = $clog2(GAP_CYC)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_len25,
    input  logic     cfg_even,
    input  logic     tx_en,
    input  tx_word_t head,
    input  logic     empty,
    output logic     pop,
    output logic     idle,
    output logic     line_a,
    output logic     line_b
);

    ser_state_e        state;
    logic [WORD_W-1:0] shreg;
    logic [4:0]        bit_idx, last_idx;
    logic [PH_W-1:0]   phase;
    logic [GC_W-1:0]   gap_cnt;
    logic              active;

    assign idle   = (state == SER_IDLE);
    assign pop    = idle & tx_en & ~empty;
    assign active = (state == SER_BITS) && (phase < PH_W'(HALF_BIT_CYC));
    assign line_a = active & shreg[0];
    assign line_b = active & ~shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SER_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            last_idx <= '0;
            phase    <= '0;
            gap_cnt  <= '0;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    if (pop) begin
                        shreg    <= frame_word(head, cfg_len25, cfg_even);
                        last_idx <= cfg_len25 ? 5'd24 : 5'd31;
                        bit_idx  <= '0;
                        phase    <= '0;
                        state    <= SER_BITS;
                    end
                end
                SER_BITS: begin
                    if (phase == PH_W'(BIT_CYC - 1)) begin
                        phase <= '0;
                        if (bit_idx == last_idx) begin
                            gap_cnt <= '0;
                            state   <= SER_GAP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= shreg >> 1;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                SER_GAP: begin
                    if (gap_cnt == GC_W'(GAP_CYC - 1)) begin
                        state <= SER_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo
    import a429_tx_pkg::*;
#(
    parameter int FIFO_DEPTH   = 8,
    parameter int HALF_BIT_CYC = 2,
    parameter int GAP_BITS     = 4,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_len25,
    input  logic              cfg_even,
    input  logic              tx_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    output logic              line_a,
    output logic              line_b,
    output logic              tx_ready,
    output logic              wr_err
);

    tx_word_t      head;
    logic          empty, pop, idle;
    logic [CW-1:0] fill_cnt;

    assign tx_ready = idle & empty;

    a429_tx_store #(.DEPTH(FIFO_DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .pop      (pop),
        .set_done (tx_ready),
        .head     (head),
        .empty    (empty),
        .fill     (fill_cnt),
        .err      (wr_err)
    );

    a429_tx_serial #(.HALF_BIT_CYC(HALF_BIT_CYC), .GAP_BITS(GAP_BITS)) u_serial (
        .clk       (clk),
        .rst       (rst),
        .cfg_len25 (cfg_len25),
        .cfg_even  (cfg_even),
        .tx_en     (tx_en),
        .head      (head),
        .empty     (empty),
        .pop       (pop),
        .idle      (idle),
        .line_a    (line_a),
        .line_b    (line_b)
    );

endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          line_a,
    input logic          line_b,
    input logic          tx_ready,
    input logic          wr_hi,
    input logic          wr_err,
    input logic [CW-1:0] fill
);

    // R11
    rails_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_a && line_b));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err);

    // R9
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (!line_a && !line_b));

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !wr_hi) |=> tx_ready);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

endmodule

bind a429_tx_fifo a429_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .line_a   (line_a),
    .line_b   (line_b),
    .tx_ready (tx_ready),
    .wr_hi    (wr_hi),
    .wr_err   (wr_err),
    .fill     (fill_cnt)
);

// File: tb/test_a429_tx_fifo.sv
module test_a429_tx_fifo;

    localparam int HALF = 2;
    localparam int GAP  = 4;
    localparam int BITC = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_len25 = 1'b0;
    logic        cfg_even = 1'b0;
    logic        tx_en = 1'b0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic        line_a, line_b, tx_ready, wr_err;

    always #2.5 clk = ~clk;

    a429_tx_fifo #(.FIFO_DEPTH(8), .HALF_BIT_CYC(HALF), .GAP_BITS(GAP)) i_a429_tx_fifo (
        .clk(clk), .rst(rst), .cfg_len25(cfg_len25), .cfg_even(cfg_even),
        .tx_en(tx_en), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .line_a(line_a), .line_b(line_b), .tx_ready(tx_ready), .wr_err(wr_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // ---------------- line monitor ----------------
    int          cyc = 0;
    int          cur_len = 32;
    logic [31:0] rx_buf [0:31];
    logic [31:0] rx_acc = '0;
    int          rx_n = 0, rx_cnt = 0, bits_seen = 0;
    int          shape_bad = 0, gap_bad = 0, hi_run = 0, last_rise = 0;
    logic        pa = 0, pb = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        bit got;
        bit val;
        got = 0;
        val = 0;
        if (line_a && !pa) begin got = 1; val = 1; end
        if (line_b && !pb) begin got = 1; val = 0; end
        if (line_a || line_b) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != HALF) shape_bad++;
            hi_run = 0;
        end
        if (got) begin
            if (rx_cnt == 0 && rx_n > 0 && (cyc - last_rise) < BITC * (1 + GAP)) gap_bad++;
            if (rx_cnt > 0 && (cyc - last_rise) != BITC) shape_bad++;
            last_rise = cyc;
            rx_acc[rx_cnt] = val;
            rx_cnt++;
            bits_seen++;
            if (rx_cnt == cur_len) begin
                rx_buf[rx_n] = rx_acc;
                rx_n++;
                rx_cnt = 0;
                rx_acc = '0;
            end
        end
        pa = line_a;
        pb = line_b;
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] exp_frame(logic len25, logic even, logic [31:0] d);
        int n, pos, ones;
        logic [31:0] r;
        n    = len25 ? 24 : 31;
        pos  = n;
        ones = 0;
        r    = '0;
        for (int i = 0; i < n; i++) begin
            r[i] = d[i];
            if (d[i]) ones++;
        end
        r[pos] = even ? (ones % 2 == 1) : (ones % 2 == 0);
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(bit hi, logic [15:0] d);
        @(negedge clk);
        wr_data = d;
        if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
        @(negedge clk);
        wr_hi = 1'b0;
        wr_lo = 1'b0;
    endtask

    task automatic put_word(logic [31:0] w);
        strobe(0, w[15:0]);
        strobe(1, w[31:16]);
    endtask

    task automatic wait_ready(string req);
        int t;
        t = 0;
        @(negedge clk);
        while (!tx_ready && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(tx_ready, req, {31'd0, tx_ready}, 32'd1);
    endtask

    task automatic do_reset();
        tx_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // {len25, even, host word}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b0, 32'h0000_0000},
        {1'b0, 1'b1, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 32'h8123_4567},
        {1'b1, 1'b0, 32'hABCD_1234},
        {1'b1, 1'b1, 32'h00FF_00FF},
        {1'b0, 1'b1, 32'h7FFF_FFFE}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base, bits0;
        logic [31:0] wa, wb, ww;

        do_reset();
        // R1 reset state
        check(!line_a && !line_b, "R1", {30'd0, line_a, line_b}, 32'd0);
        check(tx_ready, "R1", {31'd0, tx_ready}, 32'd1);
        check(!wr_err, "R1", {31'd0, wr_err}, 32'd0);

        // R2: a staged half alone never starts anything
        tx_en = 1'b1;
        strobe(0, 16'h1234);
        repeat (40) @(negedge clk);
        check(bits_seen == 0, "R2", bits_seen, 0);
        check(tx_ready, "R2", {31'd0, tx_ready}, 32'd1);

        // R3 R4 R5 R6: vector table
        foreach (VEC[k]) begin
            cfg_len25 = VEC[k][33];
            cfg_even  = VEC[k][32];
            cur_len   = VEC[k][33] ? 25 : 32;
            base      = rx_n;
            put_word(VEC[k][31:0]);
            wait_ready("R9");
            check(rx_n == base + 1, "R2", rx_n, base + 1);
            check(rx_buf[base] == exp_frame(VEC[k][33], VEC[k][32], VEC[k][31:0]),
                  VEC[k][33] ? "R5/R6" : "R4/R6", rx_buf[base],
                  exp_frame(VEC[k][33], VEC[k][32], VEC[k][31:0]));
        end
        check(shape_bad == 0, "R3", shape_bad, 0);

        // R10: lock after the second word of a set begins
        cfg_len25 = 1'b0;
        cfg_even  = 1'b0;
        cur_len   = 32;
        base      = rx_n;
        wa = 32'h1357_9BDF;
        wb = 32'h2468_ACE0;
        put_word(wa);
        put_word(wb);
        check(!wr_err, "R10", {31'd0, wr_err}, 32'd0);
        while (!(rx_n == base + 1 && rx_cnt >= 1)) @(negedge clk);
        put_word(32'hDEAD_BEEF);
        check(wr_err, "R10", {31'd0, wr_err}, 32'd1);
        wait_ready("R9");
        check(rx_n == base + 2, "R10", rx_n, base + 2);
        check(rx_buf[base] == exp_frame(0, 0, wa), "R10", rx_buf[base], exp_frame(0, 0, wa));
        check(rx_buf[base + 1] == exp_frame(0, 0, wb), "R10", rx_buf[base + 1], exp_frame(0, 0, wb));
        // the locked low-half write must not have reached the staging register
        strobe(1, 16'h0F0F);
        wait_ready("R9");
        ww = {16'h0F0F, wb[15:0]};
        check(rx_buf[base + 2] == exp_frame(0, 0, ww), "R10", rx_buf[base + 2], exp_frame(0, 0, ww));
        check(wr_err, "R11", {31'd0, wr_err}, 32'd1);

        // R7 R8 R9: fill the queue with sending held off
        do_reset();
        check(!wr_err, "R1", {31'd0, wr_err}, 32'd0);
        base  = rx_n;
        bits0 = bits_seen;
        for (int i = 0; i < 8; i++) put_word(32'h0101_0101 * (i + 1) ^ 32'h8000_0000);
        check(!tx_ready, "R9", {31'd0, tx_ready}, 32'd0);
        repeat (20) @(negedge clk);
        check(bits_seen == bits0, "R9", bits_seen, bits0);
        check(!wr_err, "R7", {31'd0, wr_err}, 32'd0);
        put_word(32'hFFFF_0000);
        check(wr_err, "R7", {31'd0, wr_err}, 32'd1);
        tx_en = 1'b1;
        wait_ready("R9");
        check(rx_n == base + 8, "R7", rx_n, base + 8);
        for (int i = 0; i < 8; i++) begin
            ww = 32'h0101_0101 * (i + 1) ^ 32'h8000_0000;
            check(rx_buf[base + i] == exp_frame(0, 0, ww), "R7", rx_buf[base + i], exp_frame(0, 0, ww));
        end
        check(gap_bad == 0, "R8", gap_bad, 0);
        check(shape_bad == 0, "R3", shape_bad, 0);
        repeat (200) @(negedge clk);
        check(rx_n == base + 8, "R7", rx_n, base + 8);
        check(tx_ready && !line_a && !line_b, "R9", {29'd0, tx_ready, line_a, line_b}, 32'd4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule